// File: doc/BRIEF.md
# Pulse-Coded Level Link Codec

This block carries one slowly changing logic level across a channel that can only pass short pulses, such as a transformer-coupled isolation barrier. On the sending side an encoder watches the level and turns every rising edge into a one-cycle pulse on a "set" line and every falling edge into a one-cycle pulse on a "clear" line. While the level is idle, the encoder repeats the current level at a fixed interval, so the far side stays correct even if a pulse was lost.

On the receiving side a decoder holds the level in a set/clear latch. A watchdog counts cycles since the last legal pulse. When the count reaches the timeout, the decoder assumes the sending side has lost power. It then forces its output to a passive default level and drops a link-good flag. The first legal pulse after that restores normal operation at once.

The encoder outputs and the decoder inputs are separate ports, so the channel lies outside the block. Both halves share one clock.

Top module: `pulse_link_codec`

## Requirements
- R1: On the clock edge after the sampled input changes, the encoder emits exactly one pulse lasting one cycle. A rising edge gives a pulse on `link_set_o`; a falling edge gives a pulse on `link_clr_o`.
- R2: A pulse on `chan_set_i` alone drives `rx_level_o` to 1 on the next edge. A pulse on `chan_clr_i` alone drives it to 0 on the next edge. Between pulses, `rx_level_o` holds its value.
- R3: The encoder never raises `link_set_o` and `link_clr_o` in the same cycle.
- R4: While the input is idle, the encoder emits a refresh pulse that restates the current level every REFRESH_CYCLES cycles. The spacing is counted from the last pulse it sent, so every edge restarts the interval.
- R5: A cycle with both `chan_set_i` and `chan_clr_i` high is illegal. It leaves `rx_level_o` unchanged and does not restart the watchdog.
- R6: If TIMEOUT_CYCLES consecutive cycles pass with no legal pulse, `rx_level_o` is forced to DEFAULT_LEVEL (default 1) and `link_ok_o` goes low. Idle refresh pulses keep the link good indefinitely.
- R7: After a fault, the first legal pulse raises `link_ok_o` and applies its level on the next edge.
- R8: After reset, `rx_level_o` equals DEFAULT_LEVEL, `link_ok_o` is 0, and neither encoder pulse line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level_i | input | 1 | Level to be sent |
| link_set_o | output | 1 | Encoder pulse: level is high |
| link_clr_o | output | 1 | Encoder pulse: level is low |
| chan_set_i | input | 1 | Decoder input: set pulse from the channel |
| chan_clr_i | input | 1 | Decoder input: clear pulse from the channel |
| rx_level_o | output | 1 | Recovered level |
| link_ok_o | output | 1 | High while pulses keep arriving within the timeout |

## Verification
The bench measures the exact spacing of refresh pulses, both after a single edge and after two edges in quick succession. An encoder that did not restart its interval on an edge would fire too early in that second case.

It injects a simultaneous set and clear pulse partway through a silent period. A decoder that latched either level would corrupt the output. A decoder that counted that cycle as a live pulse would expire too late, and the bench checks the expiry cycle to catch this.

It checks the cycle just before and the cycle of watchdog expiry. It also checks that one clear pulse after a fault recovers both the level and the good flag. This catches off-by-one timeouts and a sticky fault flag.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef struct packed {
        logic set;
        logic clr;
    } plc_pulse_t;

    function automatic logic plc_legal(input plc_pulse_t p);
        return p.set ^ p.clr;
    endfunction

endpackage

// File: rtl/plc_encoder.sv
module plc_encoder
    import plc_pkg::*;
#(
    parameter int   REFRESH_CYCLES = 16,
    parameter logic DEFAULT_LEVEL  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    output plc_pulse_t pulse_o
);
    localparam int CW = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] idle;
        plc_pulse_t    pulse;
    } enc_state_t;

    enc_state_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.pulse.set   = 1'b0;
        st_d.pulse.clr   = 1'b0;
        st_d.level       = level_i;
        if (level_i != st_q.level) begin
            st_d.pulse.set = level_i;
            st_d.pulse.clr = ~level_i;
            st_d.idle      = '0;
        end else if (st_q.idle == LAST) begin
            st_d.pulse.set = st_q.level;
            st_d.pulse.clr = ~st_q.level;
            st_d.idle      = '0;
        end else begin
            st_d.idle = st_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= DEFAULT_LEVEL;
            st_q.idle  <= '0;
            st_q.pulse <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_o.set && pulse_o.clr)); // R3

    AST_EDGE_MAKES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i != st_q.level) |=> (pulse_o.set == $past(level_i) && pulse_o.clr == !$past(level_i))); // R1

endmodule

// File: rtl/plc_decoder.sv
module plc_decoder
    import plc_pkg::*;
#(
    parameter int   TIMEOUT_CYCLES = 80,
    parameter logic DEFAULT_LEVEL  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  plc_pulse_t pulse_i,
    output logic       level_o,
    output logic       ok_o
);
    localparam int CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic          level;
        logic          ok;
        logic [CW-1:0] quiet;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (plc_legal(pulse_i)) begin
            st_d.level = pulse_i.set;
            st_d.ok    = 1'b1;
            st_d.quiet = '0;
        end else if (st_q.quiet == LAST) begin
            st_d.level = DEFAULT_LEVEL;
            st_d.ok    = 1'b0;
        end else begin
            st_d.quiet = st_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= DEFAULT_LEVEL;
            st_q.ok    <= 1'b0;
            st_q.quiet <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign ok_o    = st_q.ok;

    AST_SET_LATCHES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i.set && !pulse_i.clr) |=> (level_o && ok_o)); // R2

    AST_CLR_LATCHES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i.clr && !pulse_i.set) |=> (!level_o && ok_o)); // R7

    AST_BOTH_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i.set && pulse_i.clr) |=> (level_o == $past(level_o) || !ok_o)); // R5

    AST_FAULT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_o |-> (level_o == DEFAULT_LEVEL)); // R6

endmodule

// File: rtl/pulse_link_codec.sv
module pulse_link_codec
    import plc_pkg::*;
#(
    parameter int   REFRESH_CYCLES = 16,
    parameter int   TIMEOUT_CYCLES = 80,
    parameter logic DEFAULT_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_level_i,
    output logic link_set_o,
    output logic link_clr_o,
    input  logic chan_set_i,
    input  logic chan_clr_i,
    output logic rx_level_o,
    output logic link_ok_o
);
    plc_pulse_t tx_pulse;
    plc_pulse_t rx_pulse;

    assign rx_pulse.set = chan_set_i;
    assign rx_pulse.clr = chan_clr_i;

    plc_encoder #(
        .REFRESH_CYCLES(REFRESH_CYCLES),
        .DEFAULT_LEVEL (DEFAULT_LEVEL)
    ) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(tx_level_i),
        .pulse_o(tx_pulse)
    );

    plc_decoder #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
        .DEFAULT_LEVEL (DEFAULT_LEVEL)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .pulse_i(rx_pulse),
        .level_o(rx_level_o),
        .ok_o   (link_ok_o)
    );

    assign link_set_o = tx_pulse.set;
    assign link_clr_o = tx_pulse.clr;

endmodule

// File: tb/pulse_link_codec_test.sv
module pulse_link_codec_test;
    localparam int REF = 16;
    localparam int TMO = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx = 1'b1;
    logic link_set, link_clr, chan_set, chan_clr, rx_level, link_ok;
    logic loop_en = 1'b1;
    logic inj_set = 1'b0;
    logic inj_clr = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;

    always #5 clk = ~clk;

    always_comb begin
        chan_set = loop_en ? link_set : inj_set;
        chan_clr = loop_en ? link_clr : inj_clr;
    end

    pulse_link_codec #(.REFRESH_CYCLES(REF), .TIMEOUT_CYCLES(TMO), .DEFAULT_LEVEL(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .tx_level_i(tx),
        .link_set_o(link_set), .link_clr_o(link_clr),
        .chan_set_i(chan_set), .chan_clr_i(chan_clr),
        .rx_level_o(rx_level), .link_ok_o(link_ok)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rx_level == 1'b1, "R8 rx default", rx_level, 1);
        chk(link_ok == 1'b0, "R8 link_ok low", link_ok, 0);
        chk({link_set, link_clr} == 2'b00, "R8 no pulses", {link_set, link_clr}, 0);
    endtask

    // Drive an edge and check the pulse and the latched level (R1, R2, R7)
    task automatic t_edge(input logic lvl);
        tx = lvl;
        @(negedge clk);
        chk(link_set == lvl && link_clr == !lvl, "R1 edge pulse", {link_set, link_clr}, {lvl, !lvl});
        @(negedge clk);
        chk({link_set, link_clr} == 2'b00, "R1 single cycle", {link_set, link_clr}, 0);
        chk(rx_level == lvl, "R2 latched level", rx_level, lvl);
        chk(link_ok == 1'b1, "R7 first pulse sets link_ok", link_ok, 1);
    endtask

    // Edge then count refresh pulses and their spacing (R4, R3)
    task automatic t_refresh(input logic lvl);
        int wrong = 0;
        tx = lvl;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (link_set && link_clr) wrong++;
            if (i == 1 || i == 17 || i == 33) begin
                if (!(link_set == lvl && link_clr == !lvl)) wrong++;
            end else if (link_set || link_clr) begin
                wrong++;
            end
        end
        chk(wrong == 0, "R4 refresh spacing and level", wrong, 0);
        chk(rx_level == lvl, "R2 holds across refresh", rx_level, lvl);
        chk(wrong == 0, "R3 never both lines", wrong, 0);
    endtask

    // Two edges eight cycles apart: refresh counts from the second (R4)
    task automatic t_restart();
        int wrong = 0;
        tx = 1'b0;
        for (int i = 1; i <= 8; i++) @(negedge clk);
        tx = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (i == 1 || i == 17) begin
                if (!(link_set && !link_clr)) wrong++;
            end else if (link_set || link_clr) begin
                wrong++;
            end
        end
        chk(wrong == 0, "R4 interval restarts on edge", wrong, 0);
    endtask

    // Long idle with the loop closed keeps the link good (R6)
    task automatic t_alive();
        int drops = 0;
        for (int i = 0; i < 3 * TMO; i++) begin
            @(negedge clk);
            if (!link_ok) drops++;
        end
        chk(drops == 0, "R6 refresh keeps link good", drops, 0);
    endtask

    // Cut the channel, inject pulses by hand (R5, R6, R7)
    task automatic t_watchdog();
        loop_en = 1'b0;
        inj_clr = 1'b1;
        @(negedge clk);
        inj_clr = 1'b0;
        chk(rx_level == 1'b0, "R2 clear pulse latches low", rx_level, 0);
        for (int i = 2; i <= 81; i++) begin
            if (i == 50) begin
                inj_set = 1'b1;
                inj_clr = 1'b1;
            end
            @(negedge clk);
            if (i == 50) begin
                inj_set = 1'b0;
                inj_clr = 1'b0;
            end
            if (i == 51) chk(rx_level == 1'b0, "R5 illegal pair ignored", rx_level, 0);
            if (i == 80) chk(link_ok == 1'b1, "R6 alive before timeout", link_ok, 1);
            if (i == 81) begin
                chk(link_ok == 1'b0, "R5 R6 expiry not delayed by illegal pair", link_ok, 0);
                chk(rx_level == 1'b1, "R6 default level on fault", rx_level, 1);
            end
        end
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk(link_ok == 1'b0 && rx_level == 1'b1, "R6 fault holds", {link_ok, rx_level}, 1);
        inj_clr = 1'b1;
        @(negedge clk);
        inj_clr = 1'b0;
        chk(link_ok == 1'b1, "R7 recovery flag", link_ok, 1);
        chk(rx_level == 1'b0, "R7 recovery level", rx_level, 0);
        loop_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reset();
        t_edge(1'b0);
        t_edge(1'b1);
        t_refresh(1'b0);
        t_refresh(1'b1);
        t_restart();
        t_alive();
        t_watchdog();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(1_000_000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule